// File: doc/BRIEF.md
# Radio Transmit Packet Sequencer

This block drives one packet transmission through an external radio that is reached over a simple register-access port (request/acknowledge, one register read or write per handshake). A single start pulse with a byte count makes it clear stale transmit status, point the radio's interrupt line at the data-register-empty condition, and switch the radio into transmit. It then waits a fixed synthesizer-settle time plus one extra preamble period before it loads any data.

Bytes are fetched from a local transmit buffer through a combinational read port (address out, data in the same cycle). Each byte is written to the radio's data register, and the next one is held back until the interrupt line reports that the register is empty. After the last byte the interrupt source is switched to transmit-done. Once that fires, the radio is returned to idle and its transmit status is read once more. That final status byte is presented together with a one-cycle done pulse. If the interrupt line stays low longer than a programmable limit, the wait is abandoned, the radio is still forced idle and its status read, and an error flag is raised.

Top module: `radio_tx_seq`

## Requirements
- R1: After reset, `done_o`, `err_o`, `reg_req_o` are 0 and `status_o` is 0x00.
- R2: `reg_req_o` stays high with `reg_wr_o`, `reg_addr_o` and `reg_wdata_o` unchanged until the cycle `reg_ack_i` is sampled high, and falls in the following cycle.
- R3: A packet opens with exactly these accesses in order: read of address 0x0E, write of 0x01 to address 0x0D, write of 0x50 to address 0x03.
- R4: The access after the transmit-enable write is not requested until at least SETTLE_CYC + PREAMBLE_CYC cycles after that write was acknowledged.
- R5: Buffer bytes 0 to L-1 (L = effective length) are written in index order to address 0x0F, `buf_addr_o` giving the index. A byte after the first is not requested until `irq_i` has been seen high after the previous byte's write.
- R6: After the last byte the block writes 0x02 to 0x0D, waits for `irq_i` high, writes 0x00 to 0x03, and reads 0x0E. It then pulses `done_o` for exactly one cycle. A normal packet therefore makes L + 6 accesses.
- R7: A length of 0 makes no write to 0x0F, but still does the done-select write, the done wait, the idle write and the status read (6 accesses).
- R8: A length above MAX_LEN (16) is treated as MAX_LEN.
- R9: If `irq_i` stays low for more than TIMEOUT_CYC cycles in any interrupt wait, no further data or done-select write is made. The block writes 0x00 to 0x03, reads 0x0E, and finishes with `err_o` = 1. `err_o` is 0 after a packet with no timeout and is cleared by the next start.
- R10: A start pulse while a packet is in progress is ignored; the running packet keeps its length.
- R11: `status_o` carries the value returned by the closing read of 0x0E, not the opening one, and holds it until the next packet completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a packet (taken only when idle) |
| len_i | input | 5 | Number of bytes to send, sampled with start_i |
| buf_addr_o | output | 4 | Transmit buffer read index |
| buf_data_i | input | 8 | Transmit buffer byte at buf_addr_o (same cycle) |
| reg_req_o | output | 1 | Register access request |
| reg_wr_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | 6 | Radio register address |
| reg_wdata_o | output | 8 | Write data |
| reg_ack_i | input | 1 | Access completed (read data valid this cycle) |
| reg_rdata_i | input | 8 | Read data |
| irq_i | input | 1 | Radio interrupt line, active high |
| done_o | output | 1 | One-cycle pulse: packet finished |
| status_o | output | 8 | Final transmit status byte |
| err_o | output | 1 | Last packet ended on an interrupt timeout |

## Verification
The assertions take three things for granted about the inputs. The register port acknowledges only while a request is pending. The buffer read returns data in the same cycle as the address. `reset` is applied from time zero. The bench's radio model raises `reg_ack_i` for a single cycle, only in response to a visible request. It raises `irq_i` a chosen number of cycles after each data or done-select write, or withholds it to force a timeout. Start pulses are driven between clock edges, including one deliberately issued mid-packet.

// File: rtl/radio_tx_pkg.sv
// Package: shared register addresses, values, state encoding and the
// register-operation record used by the transmit sequencer.
package radio_tx_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    // Radio register addresses the sequence touches
    localparam logic [ADDR_W-1:0] RA_CTRL    = 6'h03;
    localparam logic [ADDR_W-1:0] RA_IRQ_EN  = 6'h0D;
    localparam logic [ADDR_W-1:0] RA_TX_STAT = 6'h0E;
    localparam logic [ADDR_W-1:0] RA_TX_DATA = 6'h0F;

    // Values written during the sequence
    localparam logic [DATA_W-1:0] V_EN_EMPTY  = 8'h01;
    localparam logic [DATA_W-1:0] V_EN_DONE   = 8'h02;
    localparam logic [DATA_W-1:0] V_CTRL_TX   = 8'h50;
    localparam logic [DATA_W-1:0] V_CTRL_IDLE = 8'h00;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLR_STAT,
        S_EN_EMPTY,
        S_CTRL_TX,
        S_SETTLE,
        S_PREAMBLE,
        S_DATA,
        S_WAIT_EMPTY,
        S_EN_DONE,
        S_WAIT_DONE,
        S_CTRL_IDLE,
        S_FINAL_STAT
    } seq_state_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_op_t;

endpackage

// File: rtl/rtx_wait_timer.sv
// Module: loadable down-counter used for the fixed delays and for the
// interrupt-wait timeout. Assumes load_i is a single-cycle strobe; when not
// loading, the count falls by one per cycle and rests at zero.
module rtx_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count state: reload on strobe, otherwise decrement toward zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

    // R9: the counter only moves down or is reloaded, never wraps upward
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0) || $past(load_i));

endmodule

// File: rtl/rtx_reg_port.sv
// Module: holds one register access on the request/acknowledge port.
// A go strobe latches the operation and raises the request; the request
// drops the cycle after the acknowledge is seen. Assumes go_i is only
// raised while no request is pending and ack_i only while one is.
module rtx_reg_port (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go_i,
    input  radio_tx_pkg::reg_op_t         op_i,
    input  logic                          ack_i,
    output logic                          req_o,
    output logic                          wr_o,
    output logic [radio_tx_pkg::ADDR_W-1:0] addr_o,
    output logic [radio_tx_pkg::DATA_W-1:0] wdata_o,
    output logic                          done_o
);

    radio_tx_pkg::reg_op_t op_q;
    logic                  req_q;

    // Request state: latch on go, release after acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            op_q  <= '0;
        end else if (go_i && !req_q) begin
            req_q <= 1'b1;
            op_q  <= op_i;
        end else if (req_q && ack_i) begin
            req_q <= 1'b0;
        end
    end

    assign req_o   = req_q;
    assign wr_o    = op_q.wr;
    assign addr_o  = op_q.addr;
    assign wdata_o = op_q.wdata;
    assign done_o  = req_q && ack_i;

    // R2: a pending request keeps its fields until acknowledged
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !ack_i) |=> (req_q && $stable(op_q)));

    // R2: the request falls right after the acknowledge
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && ack_i) |=> !req_q);

    // R2: no new operation is launched over a pending one
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !req_q);

endmodule

// File: rtl/radio_tx_seq.sv
// Module: transmit packet sequencer. Walks the radio through status clear,
// interrupt-source select, transmit enable, settle and preamble delays, an
// interrupt-paced byte loop, a done wait, return to idle and a final status
// read. Assumes the buffer read port answers combinationally and the radio
// acknowledges each request exactly once.
module radio_tx_seq #(
    parameter int MAX_LEN      = 16,
    parameter int LEN_W        = 5,
    parameter int SETTLE_CYC   = 10000,
    parameter int PREAMBLE_CYC = 1600,
    parameter int TIMEOUT_CYC  = 50000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [LEN_W-1:0]            len_i,
    output logic [$clog2(MAX_LEN)-1:0]  buf_addr_o,
    input  logic [7:0]                  buf_data_i,
    output logic                        reg_req_o,
    output logic                        reg_wr_o,
    output logic [5:0]                  reg_addr_o,
    output logic [7:0]                  reg_wdata_o,
    input  logic                        reg_ack_i,
    input  logic [7:0]                  reg_rdata_i,
    input  logic                        irq_i,
    output logic                        done_o,
    output logic [7:0]                  status_o,
    output logic                        err_o
);
    import radio_tx_pkg::*;

    localparam int IDX_W  = $clog2(MAX_LEN);
    localparam int MAX_A  = (SETTLE_CYC > PREAMBLE_CYC) ? SETTLE_CYC : PREAMBLE_CYC;
    localparam int MAX_C  = (MAX_A > TIMEOUT_CYC) ? MAX_A : TIMEOUT_CYC;
    localparam int TMR_W  = $clog2(MAX_C + 1);
    localparam logic [TMR_W-1:0] T_SETTLE  = TMR_W'(SETTLE_CYC);
    localparam logic [TMR_W-1:0] T_PREAMB  = TMR_W'(PREAMBLE_CYC);
    localparam logic [TMR_W-1:0] T_TIMEOUT = TMR_W'(TIMEOUT_CYC);
    localparam logic [LEN_W-1:0] LEN_MAX   = LEN_W'(MAX_LEN);

    seq_state_t       state_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] idx_nxt;
    logic             launched_q;
    logic             done_q;
    logic             err_q;
    logic [7:0]       status_q;

    reg_op_t          op;
    logic             is_acc;
    logic             acc_go;
    logic             acc_done;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;

    assign idx_nxt = idx_q + LEN_W'(1);

    // Operation selection: which register access the current state needs
    always_comb begin
        op     = '0;
        is_acc = 1'b1;
        case (state_q)
            S_CLR_STAT:   op = '{wr: 1'b0, addr: RA_TX_STAT, wdata: 8'h00};
            S_EN_EMPTY:   op = '{wr: 1'b1, addr: RA_IRQ_EN,  wdata: V_EN_EMPTY};
            S_CTRL_TX:    op = '{wr: 1'b1, addr: RA_CTRL,    wdata: V_CTRL_TX};
            S_DATA:       op = '{wr: 1'b1, addr: RA_TX_DATA, wdata: buf_data_i};
            S_EN_DONE:    op = '{wr: 1'b1, addr: RA_IRQ_EN,  wdata: V_EN_DONE};
            S_CTRL_IDLE:  op = '{wr: 1'b1, addr: RA_CTRL,    wdata: V_CTRL_IDLE};
            S_FINAL_STAT: op = '{wr: 1'b0, addr: RA_TX_STAT, wdata: 8'h00};
            default:      is_acc = 1'b0;
        endcase
    end

    assign acc_go = is_acc && !launched_q;

    // Timer reload: arm the delay or timeout on entry to each wait state
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            S_CTRL_TX: if (acc_done) begin
                tmr_load = 1'b1;
                tmr_val  = T_SETTLE;
            end
            S_SETTLE: if (tmr_zero) begin
                tmr_load = 1'b1;
                tmr_val  = T_PREAMB;
            end
            S_DATA, S_EN_DONE: if (acc_done) begin
                tmr_load = 1'b1;
                tmr_val  = T_TIMEOUT;
            end
            default: ;
        endcase
    end

    rtx_wait_timer #(.CNT_W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    rtx_reg_port u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (acc_go),
        .op_i    (op),
        .ack_i   (reg_ack_i),
        .req_o   (reg_req_o),
        .wr_o    (reg_wr_o),
        .addr_o  (reg_addr_o),
        .wdata_o (reg_wdata_o),
        .done_o  (acc_done)
    );

    // Launch flag: one access per visit to an access state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launched_q <= 1'b0;
        end else if (acc_done) begin
            launched_q <= 1'b0;
        end else if (acc_go) begin
            launched_q <= 1'b1;
        end
    end

    // Sequence state, byte index, length, error and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            len_q    <= '0;
            idx_q    <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            status_q <= 8'h00;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: if (start_i) begin
                    len_q   <= (len_i > LEN_MAX) ? LEN_MAX : len_i;
                    idx_q   <= '0;
                    err_q   <= 1'b0;
                    state_q <= S_CLR_STAT;
                end
                S_CLR_STAT:  if (acc_done) state_q <= S_EN_EMPTY;
                S_EN_EMPTY:  if (acc_done) state_q <= S_CTRL_TX;
                S_CTRL_TX:   if (acc_done) state_q <= S_SETTLE;
                S_SETTLE:    if (tmr_zero) state_q <= S_PREAMBLE;
                S_PREAMBLE:  if (tmr_zero) state_q <= (len_q == '0) ? S_EN_DONE : S_DATA;
                S_DATA:      if (acc_done) state_q <= S_WAIT_EMPTY;
                S_WAIT_EMPTY: begin
                    if (irq_i) begin
                        idx_q   <= idx_nxt;
                        state_q <= (idx_nxt == len_q) ? S_EN_DONE : S_DATA;
                    end else if (tmr_zero) begin
                        err_q   <= 1'b1;
                        state_q <= S_CTRL_IDLE;
                    end
                end
                S_EN_DONE:   if (acc_done) state_q <= S_WAIT_DONE;
                S_WAIT_DONE: begin
                    if (irq_i) begin
                        state_q <= S_CTRL_IDLE;
                    end else if (tmr_zero) begin
                        err_q   <= 1'b1;
                        state_q <= S_CTRL_IDLE;
                    end
                end
                S_CTRL_IDLE: if (acc_done) state_q <= S_FINAL_STAT;
                S_FINAL_STAT: if (acc_done) begin
                    status_q <= reg_rdata_i;
                    done_q   <= 1'b1;
                    state_q  <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign buf_addr_o = idx_q[IDX_W-1:0];
    assign done_o     = done_q;
    assign status_o   = status_q;
    assign err_o      = err_q;

    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: no access is outstanding when a packet is reported finished
    a_r6_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !reg_req_o);

    // R8: the effective length never exceeds the buffer size
    a_r8_len_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LEN_MAX);

    // R5: the byte index never runs past the effective length
    a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= len_q);

    // R9: once a wait has timed out no data byte is requested
    a_r9_no_data_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && state_q != S_IDLE) |-> !(reg_req_o && reg_addr_o == RA_TX_DATA));

    // R10: a start pulse mid-packet leaves the length untouched
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && start_i) |=> $stable(len_q));

endmodule

// File: tb/radio_tx_seq_bench.sv
module radio_tx_seq_bench;

    localparam int SET = 20;
    localparam int PRE = 8;
    localparam int TMO = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [4:0] len_i = '0;
    logic [3:0] buf_addr_o;
    logic [7:0] buf_data_i;
    logic       reg_req_o, reg_wr_o;
    logic [5:0] reg_addr_o;
    logic [7:0] reg_wdata_o;
    logic       reg_ack_i = 1'b0;
    logic [7:0] reg_rdata_i = '0;
    logic       irq_i = 1'b0;
    logic       done_o, err_o;
    logic [7:0] status_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [7:0] mem [0:15];
    logic       log_wr   [0:63];
    logic [5:0] log_addr [0:63];
    logic [7:0] log_data [0:63];
    int         log_cyc  [0:63];
    int n_log = 0;
    int rd_cnt = 0;
    int ev_cnt = 0;
    int stall_at = -1;
    int irq_dly = 1;
    int irq_cnt = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign buf_data_i = mem[buf_addr_o];

    radio_tx_seq #(
        .SETTLE_CYC(SET), .PREAMBLE_CYC(PRE), .TIMEOUT_CYC(TMO)
    ) u_radio_tx_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .buf_addr_o(buf_addr_o), .buf_data_i(buf_data_i),
        .reg_req_o(reg_req_o), .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o),
        .reg_wdata_o(reg_wdata_o), .reg_ack_i(reg_ack_i), .reg_rdata_i(reg_rdata_i),
        .irq_i(irq_i), .done_o(done_o), .status_o(status_o), .err_o(err_o)
    );

    // Radio model: acknowledges accesses, logs them, drives the interrupt line
    always @(negedge clk) begin
        if (!rst_n) begin
            reg_ack_i = 1'b0;
            irq_i = 1'b0;
        end else begin
            if (irq_cnt > 0) begin
                irq_cnt = irq_cnt - 1;
                if (irq_cnt == 0) irq_i = 1'b1;
            end
            if (reg_req_o && !reg_ack_i) begin
                reg_ack_i = 1'b1;
                if (!reg_wr_o) begin
                    rd_cnt = rd_cnt + 1;
                    reg_rdata_i = 8'h5A ^ 8'(rd_cnt * 29);
                end
                if (n_log < 64) begin
                    log_wr[n_log]   = reg_wr_o;
                    log_addr[n_log] = reg_addr_o;
                    log_data[n_log] = reg_wr_o ? reg_wdata_o : reg_rdata_i;
                    log_cyc[n_log]  = cyc;
                end
                n_log = n_log + 1;
                if (reg_wr_o && reg_addr_o == 6'h0D && reg_wdata_o == 8'h01) begin
                    irq_i = 1'b1;
                    irq_cnt = 0;
                end else if (reg_wr_o && (reg_addr_o == 6'h0F ||
                             (reg_addr_o == 6'h0D && reg_wdata_o == 8'h02))) begin
                    irq_i = 1'b0;
                    irq_cnt = (ev_cnt == stall_at) ? 0 : irq_dly;
                    ev_cnt = ev_cnt + 1;
                end else if (reg_wr_o && reg_addr_o == 6'h03 && reg_wdata_o == 8'h00) begin
                    irq_i = 1'b0;
                    irq_cnt = 0;
                end
            end else begin
                reg_ack_i = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        summary_and_end();
    end

    // Run one packet and compare the register traffic with the expected list
    task automatic run_pkt(input int len, input int dly, input int stall, input bit poke);
        int L, nd, n_exp, base, first_rd, k, gap;
        bit done_sel, got;
        logic       ew [0:63];
        logic [5:0] ea [0:63];
        logic [7:0] ed [0:63];
        for (int i = 0; i < 16; i++) mem[i] = 8'((len * 37 + i * 11 + dly) & 255);
        @(negedge clk);
        n_log = 0; ev_cnt = 0; stall_at = stall; irq_dly = dly;
        first_rd = rd_cnt + 1;
        start_i = 1'b1; len_i = 5'(len);
        @(negedge clk);
        start_i = 1'b0;
        if (err_o !== 1'b0) chk(0, "R9 err cleared by start", err_o, 0);
        else chk(1, "R9", 0, 0);
        if (poke) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1; len_i = 5'd3;
            @(negedge clk);
            start_i = 1'b0;
        end
        got = 0;
        for (int t = 0; t < 4000 && !got; t++) begin
            @(negedge clk);
            if (done_o) got = 1;
        end
        chk(got, "R6 done seen", got, 1);
        if (!got) return;
        @(negedge clk);
        chk(done_o == 1'b0, "R6 done single cycle", done_o, 0);

        L = (len > 16) ? 16 : len;
        if (stall >= 0 && stall < L) begin nd = stall + 1; done_sel = 0; end
        else begin nd = L; done_sel = 1; end
        n_exp = 0;
        ew[n_exp] = 0; ea[n_exp] = 6'h0E; ed[n_exp] = 0;     n_exp++;
        ew[n_exp] = 1; ea[n_exp] = 6'h0D; ed[n_exp] = 8'h01; n_exp++;
        ew[n_exp] = 1; ea[n_exp] = 6'h03; ed[n_exp] = 8'h50; n_exp++;
        for (int i = 0; i < nd; i++) begin
            ew[n_exp] = 1; ea[n_exp] = 6'h0F; ed[n_exp] = mem[i]; n_exp++;
        end
        if (done_sel) begin ew[n_exp] = 1; ea[n_exp] = 6'h0D; ed[n_exp] = 8'h02; n_exp++; end
        ew[n_exp] = 1; ea[n_exp] = 6'h03; ed[n_exp] = 8'h00; n_exp++;
        ew[n_exp] = 0; ea[n_exp] = 6'h0E; ed[n_exp] = 0;     n_exp++;

        chk(n_log == n_exp, (L == 0) ? "R7 access count" : "R6 access count", n_log, n_exp);
        if (n_log != n_exp) return;
        for (int i = 0; i < n_exp; i++) begin
            if (i < 3) chk(log_wr[i] == ew[i] && log_addr[i] == ea[i] && (!ew[i] || log_data[i] == ed[i]),
                           "R3 opening access", {log_wr[i], log_addr[i], log_data[i]}, {ew[i], ea[i], ed[i]});
            else if (ea[i] == 6'h0F)
                chk(log_wr[i] && log_addr[i] == 6'h0F && log_data[i] == ed[i],
                    (len > 16) ? "R8 data byte" : "R5 data byte", {log_wr[i], log_addr[i], log_data[i]}, {ew[i], ea[i], ed[i]});
            else
                chk(log_wr[i] == ew[i] && log_addr[i] == ea[i] && (!ew[i] || log_data[i] == ed[i]),
                    (stall >= 0) ? "R9 closing access" : "R6 closing access",
                    {log_wr[i], log_addr[i], log_data[i]}, {ew[i], ea[i], ed[i]});
        end
        gap = log_cyc[3] - log_cyc[2];
        chk(gap >= SET + PRE, "R4 settle and preamble delay", gap, SET + PRE);
        for (int i = 1; i < nd + (done_sel ? 1 : 0); i++) begin
            base = 3 + i;
            gap = log_cyc[base] - log_cyc[base - 1];
            chk(gap >= dly, "R5 interrupt pacing", gap, dly);
        end
        if (stall >= 0) begin
            k = n_exp - 2;
            gap = log_cyc[k] - log_cyc[k - 1];
            chk(gap >= TMO, "R9 timeout length", gap, TMO);
        end
        chk(err_o == (stall >= 0), "R9 error flag", err_o, (stall >= 0));
        chk(status_o == log_data[n_exp - 1], "R11 final status", status_o, log_data[n_exp - 1]);
        chk(status_o != log_data[0], "R11 not opening status", status_o, log_data[n_exp - 1]);
        if (poke) chk(n_exp == len + 6, "R10 start ignored while busy", n_log, len + 6);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (5) @(negedge clk);
        chk(done_o == 0 && err_o == 0 && reg_req_o == 0 && status_o == 8'h00,
            "R1 reset state", {done_o, err_o, reg_req_o, status_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 0 && err_o == 0 && reg_req_o == 0 && status_o == 8'h00,
            "R1 after reset", {done_o, err_o, reg_req_o, status_o}, 0);
        // Length sweep, including lengths above the buffer size (R8) and zero (R7)
        for (int len = 0; len <= 19; len++) run_pkt(len, (len % 4) + 1, -1, 0);
        run_pkt(31, 2, -1, 0);
        // Timeouts in the byte loop and in the done wait (R9)
        run_pkt(4, 2, 1, 0);
        run_pkt(4, 2, 4, 0);
        run_pkt(0, 3, 0, 0);
        run_pkt(16, 1, 15, 0);
        run_pkt(5, 3, 0, 0);
        // Normal packet after a timeout clears the error
        run_pkt(3, 2, -1, 0);
        // Start pulse during a packet (R10)
        run_pkt(9, 3, -1, 1);
        summary_and_end();
    end

endmodule